// File: doc/BRIEF.md
# Accelerator Page Permission Gate

This block sits on the path from one untrusted accelerator to shared host memory and decides, request by request, whether the accelerator may touch a physical page. Each request names a physical page number and whether it is a read or a write. The answer is a one-cycle verdict: grant or block. Any blocked request also sets a violation flag that stays set until reset. A design places one gate in front of each accelerator.

Permissions live in a flat table in host memory with two bits per physical page. The table starts all-zero, so every page is closed until opened. The gate keeps a small fully associative cache of table lines, each line covering 512 consecutive pages. A miss stalls the request while the gate reads the line from the table, one word per beat, into the least recently used slot. The request is then judged again. A trusted translation unit opens pages through an update port each time it hands a translation to the accelerator. The same port has a downgrade mode that can close pages. Each update is applied to the cached line, if one is present, and written through to the table with a bit mask.

Top module: `acc_perm_checker`

## Requirements
- R1: After reset the cache holds no lines, no verdict is pending, the violation flag is low, the table port is idle and the update port is ready.
- R2: A request to a page whose table bits are both zero is blocked, and the block sets the violation flag.
- R3: A page's two bits sit at bit 2*(page mod 512) of its table line, and each table word is little-endian. Bit 0 of the pair is read permission and bit 1 is write permission. A read is granted only with bit 0 set, and a write only with bit 1 set.
- R4: The table line for a page is at base + (page / 512) * 128 bytes, and beat k of the line is read at that address + 8k. A table request is held with a stable address until the table accepts it.
- R5: On a miss the request is not accepted until all 16 beats of the line have returned. A hit is accepted in the same cycle it is presented.
- R6: The verdict (res_valid with res_grant or res_block) appears exactly one cycle after the cycle in which acc_valid and acc_ready are both high.
- R7: The violation flag stays high once set, whatever verdicts follow.
- R8: A normal update only adds permission. It writes one table word with a mask covering just the requested bits, and it leaves existing permission in place.
- R9: A downgrade update replaces both bits of the page with the given value. Its table write has both bits of the pair masked.
- R10: An update is applied to the cached copy of the line. Later checks of that line use the new bits with no new table read.
- R11: When all 16 slots are full, a miss evicts the line least recently filled or hit. The other lines stay cached.
- R12: When an update and a request are presented in the same cycle, the update is taken first. The request is judged against the updated permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_base | input | 32 | Byte address of the permission table |
| acc_valid | input | 1 | Accelerator request present |
| acc_ppn | input | 20 | Physical page number of the request address |
| acc_write | input | 1 | 1 = write request, 0 = read request |
| acc_ready | output | 1 | Request accepted this cycle |
| res_valid | output | 1 | Verdict strobe |
| res_grant | output | 1 | Request may proceed to memory |
| res_block | output | 1 | Request is dropped |
| violation | output | 1 | Sticky flag: some request was blocked |
| upd_valid | input | 1 | Permission update from the translation unit |
| upd_ppn | input | 20 | Page being updated |
| upd_perm | input | 2 | Bit 0 read, bit 1 write |
| upd_down | input | 1 | 1 = replace bits (downgrade), 0 = add bits |
| upd_ready | output | 1 | Update accepted this cycle |
| tbl_req | output | 1 | Table port request |
| tbl_we | output | 1 | 1 = masked write, 0 = read |
| tbl_addr | output | 32 | Table byte address |
| tbl_wdata | output | 64 | Write data |
| tbl_wmask | output | 64 | Per-bit write enable |
| tbl_ready | input | 1 | Table accepts the request this cycle |
| tbl_rvalid | input | 1 | Read data returned |
| tbl_rdata | input | 64 | Read data |

## Verification
The hardest case to reach from the ports is an eviction, because all sixteen slots must be full with a known recency order. Only then does the choice of victim show. The stimulus walks sixteen distinct table lines in a fixed order, then touches a seventeenth. It watches the table read counter to see which earlier line must be fetched again and which stays cached. A second awkward case is an update and a request arriving in the same cycle. The bench drives both on one edge and checks that the update is taken first. The table model accepts requests only two cycles in three, so held requests and multi-cycle fills are exercised throughout.

// File: rtl/perm_chk_pkg.sv
`timescale 1ns/1ps
package perm_chk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_UPD_WR
  } chk_state_e;

  localparam int PERM_RD_BIT = 0;
  localparam int PERM_WR_BIT = 1;

  // add-only merge unless the downgrade path replaces the pair
  function automatic logic [1:0] merge_perm(input logic [1:0] old_p,
                                            input logic [1:0] new_p,
                                            input logic       down);
    return down ? new_p : (old_p | new_p);
  endfunction

endpackage

// File: rtl/perm_lru.sv
`timescale 1ns/1ps
module perm_lru #(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid_i,
  output logic [IDX_W-1:0]   victim_o
);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] age_d [ENTRIES];

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int j = 0; j < ENTRIES; j++) begin
        if (IDX_W'(j) == touch_idx)
          age_d[j] = '0;
        else if (age_q[j] < age_q[touch_idx])
          age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < ENTRIES; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_i[i]) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < ENTRIES; i++)
        if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_o = IDX_W'(i);
    end
  end

  // R11: with every slot in use, the chosen victim is the oldest one
  p_victim_oldest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_i) |-> (age_q[victim_o] == IDX_W'(ENTRIES - 1)));

  // R11: a touched slot becomes the youngest
  p_touch_youngest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/perm_line_store.sv
`timescale 1ns/1ps
module perm_line_store
  import perm_chk_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int TAG_W   = 11,
  parameter  int OFF_W   = 9,
  parameter  int WORD_W  = 64,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int LINE_W  = 2 << OFF_W,
  localparam int LBIT_W  = OFF_W + 1,
  localparam int BEATS   = LINE_W / WORD_W,
  localparam int BEAT_W  = $clog2(BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [OFF_W-1:0]   lk_off,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [1:0]         lk_perm,
  output logic [ENTRIES-1:0] valid_o,
  input  logic               inv_en,
  input  logic [IDX_W-1:0]   inv_idx,
  input  logic               fill_en,
  input  logic               fill_last,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [BEAT_W-1:0]  fill_beat,
  input  logic [WORD_W-1:0]  fill_data,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               upd_en,
  input  logic [TAG_W-1:0]   upd_tag,
  input  logic [OFF_W-1:0]   upd_off,
  input  logic [1:0]         upd_perm,
  input  logic               upd_down
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  line_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] up_match;
  logic [1:0]         new_pair [ENTRIES];
  logic [LBIT_W-1:0]  lk_pos;
  logic [LBIT_W-1:0]  up_pos;
  logic [LBIT_W-1:0]  fill_pos;

  assign lk_pos   = {lk_off, 1'b0};
  assign up_pos   = {upd_off, 1'b0};
  assign fill_pos = LBIT_W'(fill_beat) << $clog2(WORD_W);
  assign valid_o  = valid_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag);
    assign up_match[g] = valid_q[g] && (tag_q[g] == upd_tag);
    assign new_pair[g] = merge_perm(line_q[g][up_pos +: 2], upd_perm, upd_down);
  end

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_idx = IDX_W'(i);
  end

  assign lk_hit  = |lk_match;
  assign lk_perm = line_q[lk_idx][lk_pos +: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_en && inv_idx == IDX_W'(i))         valid_q[i] <= 1'b0;
        else if (fill_last && fill_idx == IDX_W'(i)) valid_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && fill_idx == IDX_W'(i))
        line_q[i][fill_pos +: WORD_W] <= fill_data;
      else if (upd_en && up_match[i])
        line_q[i][up_pos +: 2] <= new_pair[i];
      if (fill_last && fill_idx == IDX_W'(i))
        tag_q[i] <= fill_tag;
    end
  end

  // R11: a line is never cached in two slots
  p_unique_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R5: beats only land in a slot that was invalidated for the fill
  p_fill_invalid_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !valid_q[fill_idx]);

endmodule

// File: rtl/acc_perm_checker.sv
`timescale 1ns/1ps
module acc_perm_checker
  import perm_chk_pkg::*;
#(
  parameter  int PPN_W          = 20,
  parameter  int TBL_AW         = 32,
  parameter  int PAGES_PER_LINE = 512,
  parameter  int WORD_W         = 64,
  parameter  int ENTRIES        = 16,
  localparam int OFF_W          = $clog2(PAGES_PER_LINE),
  localparam int TAG_W          = PPN_W - OFF_W,
  localparam int LINE_W         = 2 * PAGES_PER_LINE,
  localparam int BEATS          = LINE_W / WORD_W,
  localparam int BEAT_W         = $clog2(BEATS),
  localparam int IDX_W          = $clog2(ENTRIES),
  localparam int LB_SH          = $clog2(LINE_W / 8),
  localparam int WB_SH          = $clog2(WORD_W / 8),
  localparam int PW_W           = $clog2(WORD_W / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TBL_AW-1:0] tbl_base,
  input  logic              acc_valid,
  input  logic [PPN_W-1:0]  acc_ppn,
  input  logic              acc_write,
  output logic              acc_ready,
  output logic              res_valid,
  output logic              res_grant,
  output logic              res_block,
  output logic              violation,
  input  logic              upd_valid,
  input  logic [PPN_W-1:0]  upd_ppn,
  input  logic [1:0]        upd_perm,
  input  logic              upd_down,
  output logic              upd_ready,
  output logic              tbl_req,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [WORD_W-1:0] tbl_wdata,
  output logic [WORD_W-1:0] tbl_wmask,
  input  logic              tbl_ready,
  input  logic              tbl_rvalid,
  input  logic [WORD_W-1:0] tbl_rdata
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  chk_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  vic_q;
  logic [TAG_W-1:0]  ftag_q;
  logic [TBL_AW-1:0] wr_addr_q;
  logic [WORD_W-1:0] wr_data_q, wr_mask_q;
  logic              res_valid_q, res_grant_q, viol_q;
  logic              res_valid_d, res_grant_d, viol_d;

  logic [TAG_W-1:0]   acc_tag, upd_tag;
  logic [OFF_W-1:0]   acc_off, upd_off;
  logic               lk_hit;
  logic [IDX_W-1:0]   lk_idx;
  logic [1:0]         lk_perm;
  logic [ENTRIES-1:0] slot_valid;
  logic [IDX_W-1:0]   victim;
  logic               is_idle, upd_take, acc_take, miss_start, acc_ok;
  logic               fill_we, fill_last, touch_en;
  logic [IDX_W-1:0]   touch_idx;
  logic [TBL_AW-1:0]  upd_addr, fill_addr;
  logic [1:0]         upd_pmask;
  logic [PW_W:0]      upd_bitpos;

  assign acc_tag = acc_ppn[PPN_W-1:OFF_W];
  assign acc_off = acc_ppn[OFF_W-1:0];
  assign upd_tag = upd_ppn[PPN_W-1:OFF_W];
  assign upd_off = upd_ppn[OFF_W-1:0];

  assign is_idle    = (state_q == ST_IDLE);
  assign upd_take   = is_idle && upd_valid;
  assign acc_take   = is_idle && !upd_valid && acc_valid && lk_hit;
  assign miss_start = is_idle && !upd_valid && acc_valid && !lk_hit;
  assign acc_ok     = acc_write ? lk_perm[PERM_WR_BIT] : lk_perm[PERM_RD_BIT];
  assign fill_we    = (state_q == ST_FILL_WAIT) && tbl_rvalid;
  assign fill_last  = fill_we && (beat_q == BEAT_W'(BEATS - 1));
  assign touch_en   = acc_take || fill_last;
  assign touch_idx  = acc_take ? lk_idx : vic_q;

  // write-through word for an update: mask only the bits it may change
  assign upd_pmask  = upd_down ? 2'b11 : upd_perm;
  assign upd_bitpos = {upd_ppn[PW_W-1:0], 1'b0};
  assign upd_addr   = tbl_base + (TBL_AW'(upd_tag) << LB_SH)
                    + (TBL_AW'(upd_off[OFF_W-1:PW_W]) << WB_SH);
  assign fill_addr  = tbl_base + (TBL_AW'(ftag_q) << LB_SH)
                    + (TBL_AW'(beat_q) << WB_SH);

  perm_line_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .OFF_W   (OFF_W),
    .WORD_W  (WORD_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lk_tag    (acc_tag),
    .lk_off    (acc_off),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_perm   (lk_perm),
    .valid_o   (slot_valid),
    .inv_en    (miss_start),
    .inv_idx   (victim),
    .fill_en   (fill_we),
    .fill_last (fill_last),
    .fill_idx  (vic_q),
    .fill_beat (beat_q),
    .fill_data (tbl_rdata),
    .fill_tag  (ftag_q),
    .upd_en    (upd_take),
    .upd_tag   (upd_tag),
    .upd_off   (upd_off),
    .upd_perm  (upd_perm),
    .upd_down  (upd_down)
  );

  perm_lru #(.ENTRIES(ENTRIES)) lru_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .valid_i   (slot_valid),
    .victim_o  (victim)
  );

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (upd_take)        state_d = ST_UPD_WR;
        else if (miss_start) begin
          state_d = ST_FILL_REQ;
          beat_d  = '0;
        end
      end
      ST_FILL_REQ:  if (tbl_ready) state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: begin
        if (tbl_rvalid) begin
          if (fill_last) state_d = ST_IDLE;
          else begin
            beat_d  = beat_q + 1'b1;
            state_d = ST_FILL_REQ;
          end
        end
      end
      ST_UPD_WR:    if (tbl_ready) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    res_valid_d = acc_take;
    res_grant_d = acc_take && acc_ok;
    viol_d      = viol_q || (acc_take && !acc_ok);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= ST_IDLE;
      beat_q      <= '0;
      res_valid_q <= 1'b0;
      res_grant_q <= 1'b0;
      viol_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      beat_q      <= beat_d;
      res_valid_q <= res_valid_d;
      res_grant_q <= res_grant_d;
      viol_q      <= viol_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_start) begin
      vic_q  <= victim;
      ftag_q <= acc_tag;
    end
    if (upd_take) begin
      wr_addr_q <= upd_addr;
      wr_data_q <= WORD_W'(upd_perm) << upd_bitpos;
      wr_mask_q <= WORD_W'(upd_pmask) << upd_bitpos;
    end
  end

  assign acc_ready = acc_take;
  assign upd_ready = is_idle;
  assign res_valid = res_valid_q;
  assign res_grant = res_grant_q;
  assign res_block = res_valid_q && !res_grant_q;
  assign violation = viol_q;
  assign tbl_req   = (state_q == ST_FILL_REQ) || (state_q == ST_UPD_WR);
  assign tbl_we    = (state_q == ST_UPD_WR);
  assign tbl_addr  = tbl_we ? wr_addr_q : fill_addr;
  assign tbl_wdata = wr_data_q;
  assign tbl_wmask = wr_mask_q;

  // R6: a verdict follows every accepted request, one cycle later
  p_verdict_follows_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && acc_ready) |=> res_valid);

  // R6: no verdict without an accepted request
  p_no_spurious_verdict_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(acc_valid && acc_ready) |=> !res_valid);

  // R7: the violation flag never falls
  p_violation_sticky_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    violation |=> violation);

  // R2: every block is recorded as a violation
  p_block_flags_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_block |-> violation);

  // R4: a table request holds its address until taken
  p_hold_request_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tbl_req && !tbl_ready) |=> (tbl_req && $stable(tbl_addr)));

  // R5: nothing is accepted while a fill or a write-through is in flight
  p_stall_busy_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    tbl_req |-> !acc_ready);

  // R8/R9: a write-through touches at most one bit pair
  p_one_pair_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tbl_req && tbl_we) |-> ($countones(tbl_wmask) <= 2));

  // R12: an update presented with a request goes first
  p_update_first_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid |-> !acc_ready);

endmodule

// File: tb/acc_perm_checker_tb_top.sv
`timescale 1ns/1ps
module acc_perm_checker_tb_top;

  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [19:0] acc_ppn;
  logic        acc_ready, res_valid, res_grant, res_block, violation;
  logic        upd_valid, upd_down, upd_ready;
  logic [19:0] upd_ppn;
  logic [1:0]  upd_perm;
  logic        tbl_req, tbl_we, tbl_ready, tbl_rvalid;
  logic [31:0] tbl_addr;
  logic [63:0] tbl_wdata, tbl_wmask, tbl_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  acc_perm_checker dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_base(BASE),
    .acc_valid(acc_valid), .acc_ppn(acc_ppn), .acc_write(acc_write),
    .acc_ready(acc_ready), .res_valid(res_valid), .res_grant(res_grant),
    .res_block(res_block), .violation(violation),
    .upd_valid(upd_valid), .upd_ppn(upd_ppn), .upd_perm(upd_perm),
    .upd_down(upd_down), .upd_ready(upd_ready),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .tbl_wmask(tbl_wmask), .tbl_ready(tbl_ready),
    .tbl_rvalid(tbl_rvalid), .tbl_rdata(tbl_rdata)
  );

  // table memory model: 32 lines of 16 words, accepts 2 of every 3 cycles,
  // read data returns two cycles after acceptance
  logic [63:0] tmem [0:511];
  int          cyc = 0;
  logic        rv0 = 1'b0, rv1 = 1'b0;
  logic [63:0] rd0, rd1;
  int          rd_total = 0, wr_total = 0;
  logic [31:0] rd_last_addr, wr_last_addr;
  logic [63:0] wr_last_data, wr_last_mask;
  logic [31:0] rel;

  assign rel        = tbl_addr - BASE;
  assign tbl_ready  = (cyc % 3) != 2;
  assign tbl_rvalid = rv1;
  assign tbl_rdata  = rd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rv0 <= 1'b0;
    rv1 <= rv0;
    rd1 <= rd0;
    if (tbl_req && tbl_ready) begin
      if (tbl_we) begin
        tmem[rel[11:3]] <= (tmem[rel[11:3]] & ~tbl_wmask) | (tbl_wdata & tbl_wmask);
        wr_total     <= wr_total + 1;
        wr_last_addr <= tbl_addr;
        wr_last_data <= tbl_wdata;
        wr_last_mask <= tbl_wmask;
      end else begin
        rv0          <= 1'b1;
        rd0          <= tmem[rel[11:3]];
        rd_total     <= rd_total + 1;
        rd_last_addr <= tbl_addr;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // present one request and return its verdict and the cycles it waited
  task automatic do_req(input logic [19:0] ppn, input logic wr,
                        output logic g, output logic b, output int waitc);
    @(negedge clk);
    acc_ppn = ppn; acc_write = wr; acc_valid = 1'b1;
    waitc = 0;
    #1;
    while (!acc_ready && waitc < 5000) begin
      @(negedge clk); #1;
      waitc++;
    end
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    check(res_valid === 1'b1, "R6", "verdict strobe", 64'(res_valid), 64'd1);
    g = res_grant;
    b = res_block;
  endtask

  task automatic do_upd(input logic [19:0] ppn, input logic [1:0] perm,
                        input logic down);
    int w0, k;
    w0 = wr_total;
    @(negedge clk);
    upd_ppn = ppn; upd_perm = perm; upd_down = down; upd_valid = 1'b1;
    #1;
    k = 0;
    while (!upd_ready && k < 100) begin @(negedge clk); #1; k++; end
    @(negedge clk);
    upd_valid = 1'b0;
    k = 0;
    while (wr_total == w0 && k < 100) begin @(negedge clk); k++; end
  endtask

  task automatic t_reset();
    #1;
    check(res_valid === 1'b0, "R1", "res_valid", 64'(res_valid), 0);
    check(violation === 1'b0, "R1", "violation", 64'(violation), 0);
    check(tbl_req === 1'b0,   "R1", "tbl_req", 64'(tbl_req), 0);
    check(upd_ready === 1'b1, "R1", "upd_ready", 64'(upd_ready), 1);
  endtask

  // R2/R4/R5: first touch of page 5 misses, fetches line 0, is blocked
  task automatic t_unmapped();
    logic g, b; int wc, r0;
    r0 = rd_total;
    do_req(20'd5, 1'b0, g, b, wc);
    check(b === 1'b1, "R2", "block on closed page", 64'(b), 1);
    check(violation === 1'b1, "R2", "violation set", 64'(violation), 1);
    check(wc >= 16, "R5", "miss stall cycles", 64'(wc), 16);
    check(rd_total - r0 == 16, "R5", "fill beats", 64'(rd_total - r0), 16);
    check(rd_last_addr == BASE + 32'd120, "R4", "last beat addr",
          64'(rd_last_addr), 64'(BASE + 32'd120));
  endtask

  // R8/R10/R3: open read on page 5, then write, through the update port
  task automatic t_upgrade();
    logic g, b; int wc, r0;
    do_upd(20'd5, 2'b01, 1'b0);
    check(wr_last_addr == BASE, "R8", "write-through addr", 64'(wr_last_addr), 64'(BASE));
    check(wr_last_mask == 64'h400, "R8", "upgrade mask", wr_last_mask, 64'h400);
    check((wr_last_data & wr_last_mask) == 64'h400, "R3", "R bit position",
          wr_last_data & wr_last_mask, 64'h400);
    r0 = rd_total;
    do_req(20'd5, 1'b0, g, b, wc);
    check(g === 1'b1, "R3", "read with R", 64'(g), 1);
    check(rd_total == r0, "R10", "no refetch after update", 64'(rd_total - r0), 0);
    check(wc == 0, "R5", "hit accepted at once", 64'(wc), 0);
    do_req(20'd5, 1'b1, g, b, wc);
    check(b === 1'b1, "R3", "write without W", 64'(b), 1);
    do_upd(20'd5, 2'b10, 1'b0);
    check(wr_last_mask == 64'h800, "R8", "add W mask", wr_last_mask, 64'h800);
    do_req(20'd5, 1'b1, g, b, wc);
    check(g === 1'b1, "R10", "write after W added", 64'(g), 1);
    do_req(20'd5, 1'b0, g, b, wc);
    check(g === 1'b1, "R8", "R kept after adding W", 64'(g), 1);
    check(violation === 1'b1, "R7", "flag stays after grants", 64'(violation), 1);
  endtask

  // R9: downgrade page 5 to read-only
  task automatic t_downgrade();
    logic g, b; int wc, r0;
    do_upd(20'd5, 2'b01, 1'b1);
    check(wr_last_mask == 64'hC00, "R9", "downgrade mask", wr_last_mask, 64'hC00);
    check((wr_last_data & wr_last_mask) == 64'h400, "R9", "downgrade data",
          wr_last_data & wr_last_mask, 64'h400);
    check(tmem[0][11:10] == 2'b01, "R9", "table pair", 64'(tmem[0][11:10]), 1);
    r0 = rd_total;
    do_req(20'd5, 1'b1, g, b, wc);
    check(b === 1'b1, "R9", "write closed", 64'(b), 1);
    do_req(20'd5, 1'b0, g, b, wc);
    check(g === 1'b1, "R9", "read kept", 64'(g), 1);
    check(rd_total == r0, "R10", "downgrade seen in cache", 64'(rd_total - r0), 0);
  endtask

  // R3/R4: page 1576 = line 3, word 1, pair 8 (bits 16..17), preloaded W only
  task automatic t_far_line();
    logic g, b; int wc;
    do_req(20'd1576, 1'b0, g, b, wc);
    check(b === 1'b1, "R3", "read on write-only page", 64'(b), 1);
    check(rd_last_addr == BASE + 32'd384 + 32'd120, "R4", "line 3 last beat",
          64'(rd_last_addr), 64'(BASE + 32'd504));
    do_req(20'd1576, 1'b1, g, b, wc);
    check(g === 1'b1, "R3", "write on write-only page", 64'(g), 1);
  endtask

  // R12: update for page 6 and a read of page 6 in the same cycle
  task automatic t_same_cycle();
    int k;
    @(negedge clk);
    upd_ppn = 20'd6; upd_perm = 2'b01; upd_down = 1'b0; upd_valid = 1'b1;
    acc_ppn = 20'd6; acc_write = 1'b0; acc_valid = 1'b1;
    #1;
    check(acc_ready === 1'b0 && upd_ready === 1'b1, "R12", "update taken first",
          64'({acc_ready, upd_ready}), 64'b01);
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    k = 0;
    while (!acc_ready && k < 200) begin @(negedge clk); #1; k++; end
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    check(res_grant === 1'b1, "R12", "request sees new perm", 64'(res_grant), 1);
  endtask

  // R11: fill all slots, then a 17th line evicts line 3 only
  task automatic t_eviction();
    logic g, b; int wc, r0;
    for (int ln = 1; ln < 16; ln++) begin
      if (ln != 3) do_req(20'(ln * 512), 1'b0, g, b, wc);
    end
    r0 = rd_total;
    do_req(20'd8192, 1'b0, g, b, wc);
    check(rd_total - r0 == 16, "R11", "line 16 fetched", 64'(rd_total - r0), 16);
    r0 = rd_total;
    do_req(20'd5, 1'b0, g, b, wc);
    check(rd_total == r0, "R11", "line 0 kept", 64'(rd_total - r0), 0);
    check(g === 1'b1, "R11", "line 0 perms kept", 64'(g), 1);
    r0 = rd_total;
    do_req(20'd1576, 1'b1, g, b, wc);
    check(rd_total - r0 == 16, "R11", "line 3 evicted", 64'(rd_total - r0), 16);
    check(g === 1'b1, "R4", "line 3 refetched from table", 64'(g), 1);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) tmem[i] = '0;
    tmem[3 * 16 + 1] = 64'h2_0000;
    rst_n = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_ppn = '0;
    upd_valid = 1'b0; upd_down = 1'b0; upd_ppn = '0; upd_perm = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unmapped();
    t_upgrade();
    t_downgrade();
    t_far_line();
    t_same_cycle();
    t_eviction();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R5 watchdog: actual 0x%0h expected 0x0", cyc);
    summary();
    $finish;
  end

endmodule